// File: doc/BRIEF.md
# Tile text layer renderer

This block turns the running pixel position of a 640x480 display into a 4-bit colour index. The screen is built from 8x8 character cells. Every pixel position is offset by a horizontal and a vertical scroll value in pixel units. The resulting point is then located on a tile map held in video memory. The visible 80-column by 60-row window can therefore glide smoothly over a larger map. The map measures 32, 64, 128 or 256 tiles on each side, and coordinates wrap around its edges.

Each map entry takes two consecutive bytes. The first byte is a character number. The second byte is a colour pair: background in the upper nibble, foreground in the lower nibble. The character number selects an 8-byte glyph in a font table, one byte per pixel row. The font table is also in video memory and has its own base address. The colour depth is one bit per pixel. A set glyph bit gives the foreground colour and a clear bit gives the background colour.

The block reads video memory through a single byte-wide read port with one cycle of latency. While a line is being drawn, it keeps a small queue of fetched cells ahead of the beam. It fills that queue during the last 16 positions of the previous line. The scroll, map and font settings arrive as plain inputs from a register block elsewhere.

Top module: `tile_text_layer`

## Requirements
- R1: While reset is asserted, `pixColour` is 0.
- R2: When `layerEn` is 0, `pixColour` is 0 on the cycle after every position.
- R3: A position with `pixX` >= 640 or `pixY` >= 480 gives colour 0 on the following cycle.
- R4: The colour for the position presented on `pixX`/`pixY` in one cycle appears on `pixColour` after the next rising clock edge, a latency of exactly one cycle.
- R5: The map entry for tile column c and row r is at `mapBase` + 2*(r*W + c), where W is the map width in tiles. The character number is the byte at that address and the colour pair is the byte at the next address. All address arithmetic is modulo 2^17.
- R6: The glyph row byte is read at `fontBase` + 8*character + (scrolled y mod 8).
- R7: Bit 7 of a glyph row byte is the leftmost pixel of the cell. A set bit outputs the lower nibble of the colour pair and a clear bit outputs the upper nibble. This holds even when the first cell of a line is only partly visible.
- R8: The map point of a pixel is (`pixX` + `hScroll`, `pixY` + `vScroll`). The tile column and row are that point divided by 8.
- R9: The tile column wraps modulo the map width and the tile row wraps modulo the map height. Each size is set by a 2-bit field: 0, 1, 2 and 3 give 32, 64, 128 and 256 tiles.
- R10: The first cells of a line are fetched while `pixX` runs through 784..799 on the line before. This uses that line's `pixY` + 1, and line 524 is followed by line 0. The position sequence must therefore include those positions, with the scroll and map settings held from `pixX` = 780 until the line ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| layerEn | input | 1 | Layer enable; 0 forces colour 0 |
| mapWidthSel | input | 2 | Map width code (0..3 = 32..256 tiles) |
| mapHeightSel | input | 2 | Map height code (0..3 = 32..256 tiles) |
| mapBase | input | 17 | Video memory byte address of the tile map |
| fontBase | input | 17 | Video memory byte address of the font table |
| hScroll | input | 12 | Horizontal scroll in pixels |
| vScroll | input | 12 | Vertical scroll in pixels |
| pixX | input | 10 | Current pixel column from the timing generator (0..799) |
| pixY | input | 10 | Current line from the timing generator (0..524) |
| vramRd | output | 1 | Video memory read strobe |
| vramAddr | output | 17 | Video memory read address |
| vramData | input | 8 | Read data, valid the cycle after `vramRd` |
| pixColour | output | 4 | Colour index of the pixel presented one cycle earlier |

## Verification
Every pixel colour is due exactly one cycle after its position is applied. The bench therefore drives a position on a falling edge and pushes the colour it computes into a queue. A monitor pops that entry 1 ns after the next rising edge and compares. Line fetches need 16 lead positions, so each tested line is preceded by the final 20 positions of the line above it. Configuration is changed only on a blank position, which expects colour 0. This keeps every queued expectation tied to the settings the design actually sampled.

// File: rtl/ttl_pkg.sv
package ttl_pkg;

  // Strobes and per-pixel facts passed from control to datapath
  typedef struct packed {
    logic       lineStart;   // reset the line fetch state
    logic       issueMap0;   // read character byte of map entry
    logic       issueMap1;   // read colour-pair byte of map entry
    logic       issueGlyph;  // read glyph row byte
    logic       captureIdx;  // character byte is on vramData
    logic       captureAttr; // colour-pair byte is on vramData
    logic       push;        // glyph byte is on vramData, store cell
    logic       pop;         // current pixel is the last of its cell
    logic       headValid;   // queue holds a cell
    logic       pixVisible;  // position inside the active area
    logic [2:0] pixPhase;    // pixel column inside its cell
  } ttl_strobe_t;

  // Tile-count mask for a 2-bit map size code
  function automatic logic [7:0] tile_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'h1F;
      2'd1:    return 8'h3F;
      2'd2:    return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/ttl_ctrl.sv
module ttl_ctrl
  import ttl_pkg::*;
#(
  parameter int H_TOTAL  = 800,
  parameter int H_VIS    = 640,
  parameter int V_VIS    = 480,
  parameter int POS_W    = 10,
  parameter int PREFETCH = 16,
  parameter int DEPTH    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             layerEn,
  input  logic [POS_W-1:0] pixX,
  input  logic [POS_W-1:0] pixY,
  input  logic [2:0]       fineX,
  output ttl_strobe_t      strobes
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [POS_W-1:0] START_X = POS_W'(H_TOTAL - PREFETCH);

  typedef enum logic [2:0] {
    S_IDLE, S_MAP0, S_MAP1, S_GLYPH, S_WAIT
  } fetch_state_e;

  fetch_state_e state, stateNext;
  logic [CNT_W-1:0] count, countNext;
  logic lineStart, visible, pushNow, popNow, roomNext;
  logic [2:0] phase;

  always_comb begin
    lineStart = (pixX == START_X);
    visible   = (pixX < POS_W'(H_VIS)) && (pixY < POS_W'(V_VIS));
    phase     = pixX[2:0] + fineX;
    pushNow   = (state == S_WAIT);
    popNow    = layerEn && visible && (count != '0) && (phase == 3'd7);
    countNext = count + CNT_W'(pushNow) - CNT_W'(popNow);
    roomNext  = (countNext < CNT_W'(DEPTH));
    stateNext = state;
    case (state)
      S_IDLE,
      S_WAIT:  stateNext = (layerEn && roomNext) ? S_MAP0 : S_IDLE;
      S_MAP0:  stateNext = S_MAP1;
      S_MAP1:  stateNext = S_GLYPH;
      S_GLYPH: stateNext = S_WAIT;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || lineStart) begin
      state <= S_IDLE;
      count <= '0;
    end else begin
      state <= stateNext;
      count <= countNext;
    end
  end

  always_comb begin
    strobes.lineStart   = lineStart;
    strobes.issueMap0   = (state == S_MAP0);
    strobes.issueMap1   = (state == S_MAP1);
    strobes.issueGlyph  = (state == S_GLYPH);
    strobes.captureIdx  = (state == S_MAP1);
    strobes.captureAttr = (state == S_GLYPH);
    strobes.push        = pushNow && !lineStart;
    strobes.pop         = popNow && !lineStart;
    strobes.headValid   = (count != '0);
    strobes.pixVisible  = visible;
    strobes.pixPhase    = phase;
  end

  // R10: every visible pixel finds a fetched cell waiting
  a_r10_head_ready: assert property (@(posedge clk) disable iff (!rstN)
    (layerEn && visible) |-> (count != '0));

  // R10: the queue is full when a visible line begins
  a_r10_full_at_line_start: assert property (@(posedge clk) disable iff (!rstN)
    (layerEn && pixX == '0 && pixY < POS_W'(V_VIS)) |-> (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/ttl_dp.sv
module ttl_dp
  import ttl_pkg::*;
#(
  parameter int V_TOTAL  = 525,
  parameter int POS_W    = 10,
  parameter int ADDR_W   = 17,
  parameter int SCROLL_W = 12,
  parameter int DEPTH    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ttl_strobe_t         strobes,
  input  logic                layerEn,
  input  logic [1:0]          mapWidthSel,
  input  logic [1:0]          mapHeightSel,
  input  logic [ADDR_W-1:0]   mapBase,
  input  logic [ADDR_W-1:0]   fontBase,
  input  logic [SCROLL_W-1:0] hScroll,
  input  logic [SCROLL_W-1:0] vScroll,
  input  logic [POS_W-1:0]    pixY,
  input  logic [7:0]          vramData,
  output logic                vramRd,
  output logic [ADDR_W-1:0]   vramAddr,
  output logic [3:0]          pixColour
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [POS_W-1:0]    nextY;
  logic [SCROLL_W-1:0] syNext;
  logic [7:0]          tileRow, tileCol, colMask, rowMask;
  logic [2:0]          fineRow;
  logic [7:0]          idxReg, attrReg;
  logic [ADDR_W-1:0]   mapOffset, mapAddr, glyphAddr;
  logic [PTR_W-1:0]    wrPtr, rdPtr;
  logic [15:0]         slot [DEPTH];
  logic [15:0]         head;
  logic                bitOn;
  logic [3:0]          colourNext;

  // Line set-up: scrolled row of the coming line and first column
  always_comb begin
    colMask = tile_mask(mapWidthSel);
    rowMask = tile_mask(mapHeightSel);
    nextY   = (pixY == POS_W'(V_TOTAL - 1)) ? '0 : pixY + 1'b1;
    syNext  = SCROLL_W'(nextY) + vScroll;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tileRow <= '0;
      tileCol <= '0;
      fineRow <= '0;
    end else if (strobes.lineStart) begin
      tileRow <= 8'(syNext >> 3) & rowMask;
      fineRow <= syNext[2:0];
      tileCol <= 8'(hScroll >> 3) & colMask;
    end else if (strobes.issueGlyph) begin
      tileCol <= (tileCol + 8'd1) & colMask;
    end
  end

  // Address generation
  always_comb begin
    mapOffset = ((ADDR_W'(tileRow) << (5 + mapWidthSel)) | ADDR_W'(tileCol)) << 1;
    mapAddr   = mapBase + mapOffset;
    glyphAddr = fontBase + ADDR_W'({idxReg, fineRow});
    vramRd    = strobes.issueMap0 | strobes.issueMap1 | strobes.issueGlyph;
    if (strobes.issueMap0)       vramAddr = mapAddr;
    else if (strobes.issueMap1)  vramAddr = mapAddr + ADDR_W'(1);
    else if (strobes.issueGlyph) vramAddr = glyphAddr;
    else                         vramAddr = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg  <= '0;
      attrReg <= '0;
    end else begin
      if (strobes.captureIdx)  idxReg  <= vramData;
      if (strobes.captureAttr) attrReg <= vramData;
    end
  end

  // Cell queue: {colour pair, glyph row}
  always_ff @(posedge clk) begin
    if (!rstN || strobes.lineStart) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push)
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strobes.pop)
        rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobes.push && wrPtr == PTR_W'(s))
        slot[s] <= {attrReg, vramData};
    end
  end

  // Pixel colour
  always_comb begin
    head       = slot[rdPtr];
    bitOn      = head[3'd7 - strobes.pixPhase];
    colourNext = 4'h0;
    if (layerEn && strobes.pixVisible && strobes.headValid)
      colourNext = bitOn ? head[11:8] : head[15:12];
  end

  always_ff @(posedge clk) begin
    if (!rstN) pixColour <= 4'h0;
    else       pixColour <= colourNext;
  end

  a_r2_disabled_dark: assert property (@(posedge clk) disable iff (!rstN)
    !layerEn |=> (pixColour == 4'h0));

  a_r3_blank_dark: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pixVisible |=> (pixColour == 4'h0));

  // R5: colour-pair byte is read from the address after the character byte
  a_r5_attr_next_byte: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueMap1 |-> (vramAddr == $past(vramAddr) + ADDR_W'(1)));

endmodule

// File: rtl/tile_text_layer.sv
module tile_text_layer
  import ttl_pkg::*;
#(
  parameter int H_TOTAL  = 800,
  parameter int V_TOTAL  = 525,
  parameter int H_VIS    = 640,
  parameter int V_VIS    = 480,
  parameter int POS_W    = 10,
  parameter int ADDR_W   = 17,
  parameter int SCROLL_W = 12,
  parameter int PREFETCH = 16,
  parameter int DEPTH    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                layerEn,
  input  logic [1:0]          mapWidthSel,
  input  logic [1:0]          mapHeightSel,
  input  logic [ADDR_W-1:0]   mapBase,
  input  logic [ADDR_W-1:0]   fontBase,
  input  logic [SCROLL_W-1:0] hScroll,
  input  logic [SCROLL_W-1:0] vScroll,
  input  logic [POS_W-1:0]    pixX,
  input  logic [POS_W-1:0]    pixY,
  output logic                vramRd,
  output logic [ADDR_W-1:0]   vramAddr,
  input  logic [7:0]          vramData,
  output logic [3:0]          pixColour
);

  ttl_strobe_t strobes;

  ttl_ctrl #(
    .H_TOTAL(H_TOTAL), .H_VIS(H_VIS), .V_VIS(V_VIS),
    .POS_W(POS_W), .PREFETCH(PREFETCH), .DEPTH(DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .layerEn(layerEn),
    .pixX(pixX), .pixY(pixY), .fineX(hScroll[2:0]),
    .strobes(strobes)
  );

  ttl_dp #(
    .V_TOTAL(V_TOTAL), .POS_W(POS_W), .ADDR_W(ADDR_W),
    .SCROLL_W(SCROLL_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .layerEn(layerEn),
    .mapWidthSel(mapWidthSel), .mapHeightSel(mapHeightSel),
    .mapBase(mapBase), .fontBase(fontBase),
    .hScroll(hScroll), .vScroll(vScroll), .pixY(pixY),
    .vramData(vramData), .vramRd(vramRd), .vramAddr(vramAddr),
    .pixColour(pixColour)
  );

endmodule

// File: tb/tile_text_layer_tb.sv
module tile_text_layer_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int H_TOTAL = 800;
  localparam int V_TOTAL = 525;
  localparam int H_VIS   = 640;
  localparam int V_VIS   = 480;
  localparam int ADDR_W  = 17;
  localparam int POS_W   = 10;

  logic              clk = 1'b0;
  logic              rstN;
  logic              layerEn;
  logic [1:0]        mapWidthSel, mapHeightSel;
  logic [ADDR_W-1:0] mapBase, fontBase;
  logic [11:0]       hScroll, vScroll;
  logic [POS_W-1:0]  pixX, pixY;
  logic              vramRd;
  logic [ADDR_W-1:0] vramAddr;
  logic [7:0]        vramData;
  logic [3:0]        pixColour;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [3:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  tile_text_layer u_dut (
    .clk(clk), .rstN(rstN), .layerEn(layerEn),
    .mapWidthSel(mapWidthSel), .mapHeightSel(mapHeightSel),
    .mapBase(mapBase), .fontBase(fontBase),
    .hScroll(hScroll), .vScroll(vScroll),
    .pixX(pixX), .pixY(pixY),
    .vramRd(vramRd), .vramAddr(vramAddr), .vramData(vramData),
    .pixColour(pixColour)
  );

  // Video memory contents are a fixed function of the address
  function automatic logic [7:0] vmem(input logic [ADDR_W-1:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd151;
    return m ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (vramRd) vramData <= vmem(vramAddr);
  end

  // Reference colour from R2, R3, R5..R9
  function automatic logic [3:0] expColour(input int x, input int y);
    int w, h, sx, sy, col, row;
    logic [ADDR_W-1:0] ea, ga;
    logic [7:0] idx, attr, g;
    if (!layerEn || x >= H_VIS || y >= V_VIS) return 4'h0;
    w   = 32 << mapWidthSel;
    h   = 32 << mapHeightSel;
    sx  = x + int'(hScroll);
    sy  = y + int'(vScroll);
    col = (sx / 8) % w;
    row = (sy / 8) % h;
    ea   = mapBase + ADDR_W'((row * w + col) * 2);
    idx  = vmem(ea);
    attr = vmem(ea + ADDR_W'(1));
    ga   = fontBase + ADDR_W'(int'(idx) * 8 + sy % 8);
    g    = vmem(ga);
    return g[3'(7 - sx % 8)] ? attr[3:0] : attr[7:4];
  endfunction

  task automatic drivePix(input int x, input int y, input string tag);
    @(negedge clk);
    pixX = POS_W'(x);
    pixY = POS_W'(y);
    expQ.push_back(expColour(x, y));
    tagQ.push_back(tag);
  endtask

  // Lead-in of the line above (R10), then the line itself plus blank tail (R3)
  task automatic runLine(input int y, input string tag);
    int py;
    py = (y == 0) ? V_TOTAL - 1 : y - 1;
    for (int x = H_TOTAL - 20; x < H_TOTAL; x++) drivePix(x, py, tag);
    for (int x = 0; x < H_VIS + 40; x++) drivePix(x, y, tag);
  endtask

  // Settings change together with a blank position (expects 0, R3)
  task automatic setCfg(input bit en, input int ws, input int hs, input int mb,
                        input int fb, input int hsc, input int vsc);
    @(negedge clk);
    layerEn      = en;
    mapWidthSel  = 2'(ws);
    mapHeightSel = 2'(hs);
    mapBase      = ADDR_W'(mb);
    fontBase     = ADDR_W'(fb);
    hScroll      = 12'(hsc);
    vScroll      = 12'(vsc);
    pixX         = POS_W'(H_VIS);
    pixY         = '0;
    expQ.push_back(4'h0);
    tagQ.push_back("R3");
  endtask

  // Monitor: scoreboard compare one cycle after each drive (R4)
  initial forever begin
    @(posedge clk);
    #1;
    if (expQ.size() > 0) begin
      logic [3:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (pixColour !== e) begin
        errors++;
        $display("FAIL %s: pixColour got %0h expected %0h at x=%0d y=%0d",
                 t, pixColour, e, pixX, pixY);
      end
    end
  end

  initial begin
    rstN = 1'b0; layerEn = 1'b0; mapWidthSel = 2'd2; mapHeightSel = 2'd2;
    mapBase = '0; fontBase = 17'h08000; hScroll = '0; vScroll = '0;
    pixX = POS_W'(H_VIS); pixY = '0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      checks++;
      if (pixColour !== 4'h0) begin
        errors++;
        $display("FAIL R1: reset colour got %0h expected 0", pixColour);
      end
      @(negedge clk);
    end
    rstN = 1'b1;

    setCfg(1'b0, 2, 2, 0, 'h08000, 9, 3);        runLine(20, "R2");
    setCfg(1'b1, 2, 2, 0, 'h08000, 0, 0);        runLine(0, "R10");
    runLine(13, "R6");
    runLine(61, "R4");
    setCfg(1'b1, 2, 2, 0, 'h08000, 3, 5);        runLine(100, "R8");
    setCfg(1'b1, 2, 2, 0, 'h08000, 7, 2);        runLine(479, "R7");
    setCfg(1'b1, 0, 0, 'h00100, 'h04000, 250, 250); runLine(200, "R9");
    setCfg(1'b1, 3, 1, 'h12345, 'h1F000, 2000, 4000); runLine(300, "R9");
    setCfg(1'b1, 1, 3, 'h1FF00, 'h10000, 1234, 17);   runLine(59, "R5");
    runLine(500, "R3");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run state got hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule